// File: doc/BRIEF.md
# CAN Message Buffer Manager

This block sits between a host and the bit-level engine of a CAN controller and works on whole frames. It holds sixteen message buffers. The host sets each one up for receiving or for transmitting. A buffer carries an 11-bit or 29-bit identifier, a data length and up to eight data bytes. From the buffers waiting to send, the block picks the next frame for the engine. It also places each received frame into a receive buffer whose masked identifier matches.

A 16-bit free-running timer is sampled when the engine reports the start of an identifier field. That sample becomes the timestamp of the frame that is stored or sent. The timer can be forced back to zero whenever buffer 0 accepts a frame, so that several stations can share a time base. Per-buffer events raise interrupt flags through a mask. Bus-off, error and wake-up events raise three more flags. A listen-only setting keeps the node off the bus.

The host uses one register port. `host_sel` picks a field, `host_idx` picks a buffer, and reads return that field at once. The engine asks for work through `tx_req`. It answers with grant, done or lost pulses, and it delivers received frames with a one-cycle valid strobe.

Top module: `can_mb_mgr`

## Requirements
- R1: After reset, every buffer is inactive (state code 0), all flags, masks and configuration bits are zero, `tx_req` and `irq` are low, and `ack_en` is high.
- R2: Host port field codes: 0 control, 1 identifier (bits 28:0), 2 data bytes 0-3, 3 data bytes 4-7, 4 configuration, 5 shared mask, 6 mask of buffer 14, 7 mask of buffer 15, 8 interrupt mask, 9 interrupt flags, 10 timer (read only). The control word has the state code in bits 1:0 (0 inactive, 1 receive empty, 2 receive full, 3 transmit pending), the extended-format flag in bit 2, the length in bits 6:3 (clamped to 8 on write) and the timestamp in bits 31:16. Writes to fields 0-3 of a buffer in state 3 are ignored.
- R3: With configuration bit 0 clear, `tx_req` is high whenever a buffer is pending and no frame is in flight, and `tx_idx` is the lowest pending buffer index.
- R4: With configuration bit 0 set, the pending buffer with the lowest arbitration key wins. A standard identifier compares as its 11 bits followed by 18 zero bits, a standard frame beats an extended frame with the same leading bits, and ties go to the lower index.
- R5: A `tx_grant` while `tx_req` is high locks the chosen buffer. `tx_done` then makes it inactive, and `tx_lost` releases it so that it is offered again.
- R6: The timer increments every cycle. An `id_start` pulse captures the timer value of that cycle, and this value becomes the timestamp written on `tx_done` or on a stored reception.
- R7: A received frame is stored only in a buffer in state 1 with the same format flag whose identifier matches under its mask. Buffers 0-13 use the shared mask and buffers 14 and 15 use their own. Standard frames compare only bits 10:0. The lowest matching index wins, and a frame with no match is discarded.
- R8: A stored frame sets the buffer to state 2 and writes the identifier, length (clamped), data and timestamp.
- R9: With configuration bit 1 set, storing a frame into buffer 0 resets the timer to zero.
- R10: A per-buffer flag (flag bits 15:0) is set on completion only if its interrupt mask bit is set. Bus-off, error and wake-up pulses set flag bits 16, 17 and 18. Writing one to a flag bit clears it, and `irq` is the OR of all flags.
- R11: With configuration bit 2 set (listen-only), `ack_en` is low, `tx_req` stays low, and error pulses do not set flag bit 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 4 | Field code for read and write |
| host_idx | input | 4 | Buffer index for read and write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Field selected by host_sel/host_idx |
| tx_req | output | 1 | A frame is ready for the engine |
| tx_idx | output | 4 | Buffer offered or in flight |
| tx_id | output | 29 | Identifier of that buffer |
| tx_ide | output | 1 | Extended-format flag of that buffer |
| tx_dlc | output | 4 | Data length of that buffer |
| tx_data | output | 64 | Data of that buffer |
| tx_grant | input | 1 | Engine accepts the offered frame |
| tx_done | input | 1 | Frame in flight sent successfully |
| tx_lost | input | 1 | Frame in flight lost or failed |
| id_start | input | 1 | Identifier field starts on the bus |
| rx_valid | input | 1 | Received frame strobe |
| rx_id | input | 29 | Received identifier |
| rx_ide | input | 1 | Received extended-format flag |
| rx_dlc | input | 4 | Received data length |
| rx_data | input | 64 | Received data |
| ack_en | output | 1 | Engine may drive acknowledge |
| busoff_evt | input | 1 | Bus-off event pulse |
| err_evt | input | 1 | Error event pulse |
| wake_evt | input | 1 | Wake-up event pulse |
| irq | output | 1 | Interrupt request |

## Verification
Several rules hold on every cycle, and the assertions check them there. A raised request always points at a pending buffer. A locked buffer stays pending until it is released. The timer steps by one unless a sync store happened. A filter hit always targets an empty buffer. No per-buffer flag rises while its mask bit is clear. Listen-only never coexists with a request.

Other behaviour shows up only in the bench's scenarios. These cover which buffer wins under each priority rule, including the standard-versus-extended ordering and index ties. They also cover the exact timestamp value written back and which receive buffer takes a frame when several match. Finally they cover that a write to a busy buffer leaves its contents unchanged.

// File: rtl/can_mb_pkg.sv
`timescale 1ns/1ps
package can_mb_pkg;
    localparam int ID_W    = 29;
    localparam int STD_W   = 11;
    localparam int DATA_W  = 64;
    localparam int DLC_W   = 4;
    localparam int MAX_DLC = 8;
    localparam int TS_W    = 16;
    localparam int KEY_W   = ID_W + 1;

    typedef enum logic [1:0] {
        MB_OFF      = 2'd0,
        MB_RX_EMPTY = 2'd1,
        MB_RX_FULL  = 2'd2,
        MB_TX_PEND  = 2'd3
    } mb_code_e;

    typedef struct packed {
        mb_code_e          code;
        logic              ide;
        logic [DLC_W-1:0]  dlc;
        logic [ID_W-1:0]   id;
        logic [DATA_W-1:0] data;
    } mb_t;

    localparam logic [3:0] SEL_CTRL  = 4'd0;
    localparam logic [3:0] SEL_ID    = 4'd1;
    localparam logic [3:0] SEL_DLO   = 4'd2;
    localparam logic [3:0] SEL_DHI   = 4'd3;
    localparam logic [3:0] SEL_CFG   = 4'd4;
    localparam logic [3:0] SEL_GMASK = 4'd5;
    localparam logic [3:0] SEL_MSKA  = 4'd6;
    localparam logic [3:0] SEL_MSKB  = 4'd7;
    localparam logic [3:0] SEL_IMASK = 4'd8;
    localparam logic [3:0] SEL_IFLAG = 4'd9;
    localparam logic [3:0] SEL_TIMER = 4'd10;

    // Standard identifiers sit in the top bits; the low bit makes standard win over extended.
    function automatic logic [KEY_W-1:0] arb_key(logic [ID_W-1:0] id, logic ide);
        return ide ? {id, 1'b1} : {id[STD_W-1:0], {(ID_W-STD_W){1'b0}}, 1'b0};
    endfunction

    function automatic logic [DLC_W-1:0] clamp_dlc(logic [DLC_W-1:0] v);
        return (v > DLC_W'(MAX_DLC)) ? DLC_W'(MAX_DLC) : v;
    endfunction
endpackage

// File: rtl/can_mb_txsel.sv
`timescale 1ns/1ps
module can_mb_txsel
    import can_mb_pkg::*;
#(
    parameter int NBUF  = 16,
    parameter int IDX_W = $clog2(NBUF)
) (
    input  logic [NBUF-1:0]            pend,
    input  logic [NBUF-1:0][KEY_W-1:0] key,
    input  logic                       by_id,
    output logic                       any,
    output logic [IDX_W-1:0]           idx
);
    logic [KEY_W-1:0] best;

    // Ascending scan: strict compare keeps the lower index on equal keys.
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (pend[i] && (!any || (by_id && key[i] < best))) begin
                any  = 1'b1;
                idx  = IDX_W'(i);
                best = key[i];
            end
        end
    end
endmodule

// File: rtl/can_mb_rxfilt.sv
`timescale 1ns/1ps
module can_mb_rxfilt
    import can_mb_pkg::*;
#(
    parameter int NBUF  = 16,
    parameter int IDX_W = $clog2(NBUF)
) (
    input  logic [NBUF-1:0]           empty,
    input  logic [NBUF-1:0]           ide,
    input  logic [NBUF-1:0][ID_W-1:0] id,
    input  logic [ID_W-1:0]           gmask,
    input  logic [ID_W-1:0]           mask_a,
    input  logic [ID_W-1:0]           mask_b,
    input  logic [ID_W-1:0]           rx_id,
    input  logic                      rx_ide,
    output logic                      hit,
    output logic [IDX_W-1:0]          idx
);
    localparam int SHARED_LAST = NBUF - 3;

    logic [NBUF-1:0] match;
    logic [ID_W-1:0] fmt;

    assign fmt = rx_ide ? '1 : ID_W'({STD_W{1'b1}});

    for (genvar g = 0; g < NBUF; g++) begin : g_cmp
        logic [ID_W-1:0] msk;
        if (g <= SHARED_LAST) begin : g_shared
            assign msk = gmask;
        end else if (g == NBUF - 2) begin : g_own_a
            assign msk = mask_a;
        end else begin : g_own_b
            assign msk = mask_b;
        end
        assign match[g] = empty[g] && (ide[g] == rx_ide)
                          && (((rx_id ^ id[g]) & msk & fmt) == '0);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/can_mb_mgr.sv
`timescale 1ns/1ps
module can_mb_mgr
    import can_mb_pkg::*;
#(
    parameter int NBUF  = 16,
    parameter int IDX_W = $clog2(NBUF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [3:0]        host_sel,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              tx_req,
    output logic [IDX_W-1:0]  tx_idx,
    output logic [ID_W-1:0]   tx_id,
    output logic              tx_ide,
    output logic [DLC_W-1:0]  tx_dlc,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_grant,
    input  logic              tx_done,
    input  logic              tx_lost,
    input  logic              id_start,
    input  logic              rx_valid,
    input  logic [ID_W-1:0]   rx_id,
    input  logic              rx_ide,
    input  logic [DLC_W-1:0]  rx_dlc,
    input  logic [DATA_W-1:0] rx_data,
    output logic              ack_en,
    input  logic              busoff_evt,
    input  logic              err_evt,
    input  logic              wake_evt,
    output logic              irq
);
    localparam int IF_W = NBUF + 3;

    typedef struct packed {
        mb_t [NBUF-1:0]            mb;
        logic [NBUF-1:0][TS_W-1:0] ts;
        logic [ID_W-1:0]           gmask;
        logic [ID_W-1:0]           mska;
        logic [ID_W-1:0]           mskb;
        logic [NBUF-1:0]           imask;
        logic [IF_W-1:0]           iflag;
        logic                      by_id;
        logic                      tsync;
        logic                      lom;
        logic [TS_W-1:0]           timer;
        logic [TS_W-1:0]           ts_hold;
        logic                      act_v;
        logic [IDX_W-1:0]          act_idx;
    } state_t;

    state_t q, d;

    logic [NBUF-1:0]            pend, empty, ide_v;
    logic [NBUF-1:0][KEY_W-1:0] keys;
    logic [NBUF-1:0][ID_W-1:0]  ids;
    logic                       sel_any, hit, busy, sync_fire;
    logic [IDX_W-1:0]           sel_idx, hit_idx;

    always_comb begin
        for (int i = 0; i < NBUF; i++) begin
            pend[i]  = (q.mb[i].code == MB_TX_PEND);
            empty[i] = (q.mb[i].code == MB_RX_EMPTY);
            ide_v[i] = q.mb[i].ide;
            ids[i]   = q.mb[i].id;
            keys[i]  = arb_key(q.mb[i].id, q.mb[i].ide);
        end
    end

    can_mb_txsel #(.NBUF(NBUF), .IDX_W(IDX_W)) u_txsel (
        .pend(pend), .key(keys), .by_id(q.by_id), .any(sel_any), .idx(sel_idx)
    );

    can_mb_rxfilt #(.NBUF(NBUF), .IDX_W(IDX_W)) u_rxfilt (
        .empty(empty), .ide(ide_v), .id(ids), .gmask(q.gmask), .mask_a(q.mska),
        .mask_b(q.mskb), .rx_id(rx_id), .rx_ide(rx_ide), .hit(hit), .idx(hit_idx)
    );

    assign busy      = (q.mb[host_idx].code == MB_TX_PEND);
    assign sync_fire = rx_valid && hit && q.tsync && (hit_idx == '0);

    always_comb begin
        d       = q;
        d.timer = sync_fire ? '0 : q.timer + 1'b1;
        if (id_start) d.ts_hold = q.timer;

        if (host_wr) begin
            case (host_sel)
                SEL_CTRL: if (!busy) begin
                    d.mb[host_idx].code = mb_code_e'(host_wdata[1:0]);
                    d.mb[host_idx].ide  = host_wdata[2];
                    d.mb[host_idx].dlc  = clamp_dlc(host_wdata[6:3]);
                end
                SEL_ID:    if (!busy) d.mb[host_idx].id = host_wdata[ID_W-1:0];
                SEL_DLO:   if (!busy) d.mb[host_idx].data[31:0]  = host_wdata;
                SEL_DHI:   if (!busy) d.mb[host_idx].data[63:32] = host_wdata;
                SEL_CFG:   {d.lom, d.tsync, d.by_id} = host_wdata[2:0];
                SEL_GMASK: d.gmask = host_wdata[ID_W-1:0];
                SEL_MSKA:  d.mska  = host_wdata[ID_W-1:0];
                SEL_MSKB:  d.mskb  = host_wdata[ID_W-1:0];
                SEL_IMASK: d.imask = host_wdata[NBUF-1:0];
                SEL_IFLAG: d.iflag = q.iflag & ~host_wdata[IF_W-1:0];
                default: ;
            endcase
        end

        if (!q.act_v) begin
            if (tx_grant && tx_req) begin
                d.act_v   = 1'b1;
                d.act_idx = sel_idx;
            end
        end else if (tx_done) begin
            d.act_v                 = 1'b0;
            d.mb[q.act_idx].code    = MB_OFF;
            d.ts[q.act_idx]         = q.ts_hold;
            if (q.imask[q.act_idx]) d.iflag[q.act_idx] = 1'b1;
        end else if (tx_lost) begin
            d.act_v = 1'b0;
        end

        if (rx_valid && hit) begin
            d.mb[hit_idx].code = MB_RX_FULL;
            d.mb[hit_idx].ide  = rx_ide;
            d.mb[hit_idx].id   = rx_id;
            d.mb[hit_idx].dlc  = clamp_dlc(rx_dlc);
            d.mb[hit_idx].data = rx_data;
            d.ts[hit_idx]      = q.ts_hold;
            if (q.imask[hit_idx]) d.iflag[hit_idx] = 1'b1;
        end

        if (busoff_evt)          d.iflag[NBUF]     = 1'b1;
        if (err_evt && !q.lom)   d.iflag[NBUF + 1] = 1'b1;
        if (wake_evt)            d.iflag[NBUF + 2] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign tx_req  = !q.lom && !q.act_v && sel_any;
    assign tx_idx  = q.act_v ? q.act_idx : sel_idx;
    assign tx_id   = q.mb[tx_idx].id;
    assign tx_ide  = q.mb[tx_idx].ide;
    assign tx_dlc  = q.mb[tx_idx].dlc;
    assign tx_data = q.mb[tx_idx].data;
    assign ack_en  = !q.lom;
    assign irq     = |q.iflag;

    always_comb begin
        case (host_sel)
            SEL_CTRL:  host_rdata = {q.ts[host_idx], 9'b0, q.mb[host_idx].dlc,
                                     q.mb[host_idx].ide, q.mb[host_idx].code};
            SEL_ID:    host_rdata = 32'(q.mb[host_idx].id);
            SEL_DLO:   host_rdata = q.mb[host_idx].data[31:0];
            SEL_DHI:   host_rdata = q.mb[host_idx].data[63:32];
            SEL_CFG:   host_rdata = {29'b0, q.lom, q.tsync, q.by_id};
            SEL_GMASK: host_rdata = 32'(q.gmask);
            SEL_MSKA:  host_rdata = 32'(q.mska);
            SEL_MSKB:  host_rdata = 32'(q.mskb);
            SEL_IMASK: host_rdata = 32'(q.imask);
            SEL_IFLAG: host_rdata = 32'(q.iflag);
            SEL_TIMER: host_rdata = 32'(q.timer);
            default:   host_rdata = '0;
        endcase
    end

    AST_REQ_HAS_PENDING: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> (q.mb[tx_idx].code == MB_TX_PEND)); // R3
    AST_LOCKED_STAYS_PENDING: assert property (@(posedge clk) disable iff (rst)
        q.act_v |-> (q.mb[q.act_idx].code == MB_TX_PEND)); // R5
    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
        !sync_fire |=> (q.timer == $past(q.timer) + 1'b1)); // R6
    AST_HIT_IS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && hit) |-> (q.mb[hit_idx].code == MB_RX_EMPTY)); // R7
    AST_FLAG_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        (q.iflag[NBUF-1:0] & ~$past(q.iflag[NBUF-1:0]) & ~$past(q.imask)) == '0); // R10
    AST_LISTEN_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !ack_en |-> !tx_req); // R11
endmodule

// File: tb/tb_can_mb_mgr.sv
`timescale 1ns/1ps
module tb_can_mb_mgr;
    import can_mb_pkg::*;
    localparam int NB = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        host_wr = 0;
    logic [3:0]  host_sel = 0;
    logic [3:0]  host_idx = 0;
    logic [31:0] host_wdata = 0;
    logic [31:0] host_rdata;
    logic        tx_req;
    logic [3:0]  tx_idx;
    logic [28:0] tx_id;
    logic        tx_ide;
    logic [3:0]  tx_dlc;
    logic [63:0] tx_data;
    logic        tx_grant = 0, tx_done = 0, tx_lost = 0, id_start = 0;
    logic        rx_valid = 0;
    logic [28:0] rx_id = 0;
    logic        rx_ide = 0;
    logic [3:0]  rx_dlc = 0;
    logic [63:0] rx_data = 0;
    logic        ack_en;
    logic        busoff_evt = 0, err_evt = 0, wake_evt = 0;
    logic        irq;

    can_mb_mgr dut (.*);

    int checks = 0, errors = 0;
    bit done_flag = 0;

    // Behavioural reference state
    int          m_code[NB];
    bit          m_ide[NB];
    bit [3:0]    m_dlc[NB];
    bit [28:0]   m_id[NB];
    bit [63:0]   m_data[NB];
    bit [15:0]   m_ts[NB];
    bit [28:0]   m_gm, m_ma, m_mb;
    bit [15:0]   m_im;
    bit [18:0]   m_if;
    bit          m_byid, m_sync, m_lom, m_act;
    int          m_aidx;
    bit [15:0]   m_timer, m_hold;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_sel();
        int idx = -1;
        bit [29:0] best = 0;
        for (int i = 0; i < NB; i++) begin
            bit [29:0] k = m_ide[i] ? {m_id[i], 1'b1} : {m_id[i][10:0], 18'b0, 1'b0};
            if (m_code[i] == 3 && (idx < 0 || (m_byid && k < best))) begin
                idx = i; best = k;
            end
        end
        return idx;
    endfunction

    function automatic int m_hit();
        for (int i = 0; i < NB; i++) begin
            bit [28:0] msk = (i < NB - 2) ? m_gm : ((i == NB - 2) ? m_ma : m_mb);
            bit [28:0] fmt = rx_ide ? 29'h1FFFFFFF : 29'h7FF;
            if (m_code[i] == 1 && m_ide[i] == rx_ide && (((rx_id ^ m_id[i]) & msk & fmt) == 0))
                return i;
        end
        return -1;
    endfunction

    function automatic bit [31:0] m_rd(bit [3:0] s, int i);
        case (s)
            0:  return {m_ts[i], 9'b0, m_dlc[i], m_ide[i], 2'(m_code[i])};
            1:  return 32'(m_id[i]);
            2:  return m_data[i][31:0];
            3:  return m_data[i][63:32];
            4:  return {29'b0, m_lom, m_sync, m_byid};
            5:  return 32'(m_gm);
            6:  return 32'(m_ma);
            7:  return 32'(m_mb);
            8:  return 32'(m_im);
            9:  return 32'(m_if);
            10: return 32'(m_timer);
            default: return 0;
        endcase
    endfunction

    function automatic bit [3:0] clampv(bit [3:0] v);
        return (v > 8) ? 4'd8 : v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NB; i++) begin
                m_code[i] = 0; m_ide[i] = 0; m_dlc[i] = 0; m_id[i] = 0; m_data[i] = 0; m_ts[i] = 0;
            end
            m_gm = 0; m_ma = 0; m_mb = 0; m_im = 0; m_if = 0;
            m_byid = 0; m_sync = 0; m_lom = 0; m_act = 0; m_aidx = 0; m_timer = 0; m_hold = 0;
        end else begin
            int s, h, hi;
            bit busy;
            bit [15:0] ot, oh;
            s = m_sel();
            h = rx_valid ? m_hit() : -1;
            hi = int'(host_idx);
            busy = (m_code[hi] == 3);
            ot = m_timer; oh = m_hold;
            m_timer = (h == 0 && m_sync) ? 16'd0 : ot + 16'd1;
            if (id_start) m_hold = ot;
            if (host_wr) begin
                case (host_sel)
                    0: if (!busy) begin
                        m_code[hi] = int'(host_wdata[1:0]); m_ide[hi] = host_wdata[2];
                        m_dlc[hi] = clampv(host_wdata[6:3]);
                    end
                    1: if (!busy) m_id[hi] = host_wdata[28:0];
                    2: if (!busy) m_data[hi][31:0] = host_wdata;
                    3: if (!busy) m_data[hi][63:32] = host_wdata;
                    4: begin m_byid = host_wdata[0]; m_sync = host_wdata[1]; m_lom = host_wdata[2]; end
                    5: m_gm = host_wdata[28:0];
                    6: m_ma = host_wdata[28:0];
                    7: m_mb = host_wdata[28:0];
                    8: m_im = host_wdata[15:0];
                    9: m_if = m_if & ~host_wdata[18:0];
                    default: ;
                endcase
            end
            if (!m_act) begin
                if (tx_grant && !m_lom && s >= 0) begin m_act = 1; m_aidx = s; end
            end else if (tx_done) begin
                m_act = 0; m_code[m_aidx] = 0; m_ts[m_aidx] = oh;
                if (m_im[m_aidx]) m_if[m_aidx] = 1;
            end else if (tx_lost) m_act = 0;
            if (h >= 0) begin
                m_code[h] = 2; m_ide[h] = rx_ide; m_id[h] = rx_id; m_dlc[h] = clampv(rx_dlc);
                m_data[h] = rx_data; m_ts[h] = oh;
                if (m_im[h]) m_if[h] = 1;
            end
            if (busoff_evt) m_if[16] = 1;
            if (err_evt && !m_lom) m_if[17] = 1;
            if (wake_evt) m_if[18] = 1;
        end
    end

    // Cycle compare against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            bit er;
            er = !m_lom && !m_act && (m_sel() >= 0);
            chk(tx_req === er, "R3 tx_req", tx_req, er);
            if (er) chk(tx_idx === 4'(m_sel()), m_byid ? "R4 tx_idx" : "R3 tx_idx", tx_idx, m_sel());
            if (m_act) chk(tx_idx === 4'(m_aidx), "R5 locked idx", tx_idx, m_aidx);
            chk(irq === (m_if != 0), "R10 irq", irq, m_if != 0);
            chk(ack_en === !m_lom, "R11 ack_en", ack_en, !m_lom);
            chk(host_rdata === m_rd(host_sel, int'(host_idx)), "R2 read", host_rdata,
                m_rd(host_sel, int'(host_idx)));
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic hw(bit [3:0] s, bit [3:0] i, bit [31:0] w);
        host_wr = 1; host_sel = s; host_idx = i; host_wdata = w;
        tick();
        host_wr = 0;
    endtask

    task automatic rd_chk(bit [3:0] s, bit [3:0] i, bit [31:0] m, bit [31:0] e, string tag);
        host_sel = s; host_idx = i; #1;
        chk((host_rdata & m) === e, tag, host_rdata & m, e);
    endtask

    task automatic rxf(bit [28:0] id, bit ide, bit [3:0] dlc, bit [63:0] data);
        rx_valid = 1; rx_id = id; rx_ide = ide; rx_dlc = dlc; rx_data = data;
        tick();
        rx_valid = 0;
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #4000000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit [31:0] t;
        repeat (3) @(negedge clk);
        #1 rst = 0;
        tick();
        // R1: reset state
        chk(tx_req === 0 && irq === 0 && ack_en === 1, "R1 outputs", {tx_req, irq, ack_en}, 3'b001);
        rd_chk(SEL_CTRL, 3, 32'hFFFFFFFF, 0, "R1 ctrl");
        rd_chk(SEL_IFLAG, 0, 32'hFFFFFFFF, 0, "R1 flags");

        hw(SEL_IMASK, 0, 32'hFFFF);
        hw(SEL_GMASK, 0, 32'h7FF);
        hw(SEL_ID, 2, 32'h1FF00000); hw(SEL_CTRL, 2, 32'h17);
        hw(SEL_ID, 5, 32'h100); hw(SEL_DLO, 5, 32'hCAFE0001); hw(SEL_CTRL, 5, 32'h0B);
        hw(SEL_ID, 9, 32'h100); hw(SEL_CTRL, 9, 32'h7B);
        rd_chk(SEL_CTRL, 9, 32'h7F, 32'h43, "R2 length clamp");
        chk(tx_req === 1 && tx_idx === 2, "R3 lowest index", tx_idx, 2);

        hw(SEL_CFG, 0, 1);
        chk(tx_idx === 5, "R4 lowest key with tie", tx_idx, 5);
        hw(SEL_ID, 5, 32'h7);
        rd_chk(SEL_ID, 5, 32'hFFFFFFFF, 32'h100, "R2 busy write ignored");

        host_sel = SEL_TIMER; #1 t = host_rdata;
        id_start = 1; tx_grant = 1; tick(); id_start = 0; tx_grant = 0;
        chk(tx_req === 0 && tx_idx === 5, "R5 locked", tx_idx, 5);
        tick(); tick();
        tx_done = 1; tick(); tx_done = 0;
        rd_chk(SEL_CTRL, 5, 32'h3, 0, "R5 done inactive");
        rd_chk(SEL_CTRL, 5, 32'hFFFF0000, t << 16, "R6 timestamp");
        rd_chk(SEL_IFLAG, 0, 32'h20, 32'h20, "R10 tx flag");
        chk(tx_req === 1 && tx_idx === 9, "R4 next winner", tx_idx, 9);

        tx_grant = 1; tick(); tx_grant = 0; tick();
        tx_lost = 1; tick(); tx_lost = 0;
        chk(tx_req === 1 && tx_idx === 9, "R5 lost reoffered", tx_idx, 9);

        hw(SEL_IFLAG, 0, 32'h20);
        rd_chk(SEL_IFLAG, 0, 32'hFFFFFFFF, 0, "R10 write-one clear");

        hw(SEL_ID, 0, 32'h55); hw(SEL_CTRL, 0, 32'h1);
        hw(SEL_ID, 1, 32'h55); hw(SEL_CTRL, 1, 32'h1);
        hw(SEL_CTRL, 14, 32'h5);
        hw(SEL_IMASK, 0, 32'hFFFD);
        rxf(29'h10000055, 0, 4'd12, 64'h1122334455667788);
        rd_chk(SEL_CTRL, 0, 32'h7F, 32'h42, "R8 stored ctrl");
        rd_chk(SEL_ID, 0, 32'hFFFFFFFF, 32'h10000055, "R8 stored id");
        rd_chk(SEL_DLO, 0, 32'hFFFFFFFF, 32'h55667788, "R8 stored data");
        rxf(29'h55, 0, 4'd2, 64'hAB);
        rd_chk(SEL_CTRL, 1, 32'h3, 32'h2, "R7 next empty match");
        rd_chk(SEL_IFLAG, 0, 32'h3, 32'h1, "R10 masked buffer flag");
        rxf(29'h55, 0, 4'd1, 64'hEE);
        rd_chk(SEL_DLO, 1, 32'hFFFFFFFF, 32'hAB, "R7 unmatched discarded");
        rxf(29'h55, 1, 4'd1, 64'h77);
        rd_chk(SEL_CTRL, 14, 32'h7, 32'h6, "R7 own mask buffer");
        hw(SEL_CTRL, 0, 32'h1);
        rxf(29'h54, 0, 4'd1, 64'h1);
        rd_chk(SEL_CTRL, 0, 32'h3, 32'h1, "R7 mask mismatch");

        hw(SEL_CFG, 0, 32'h3);
        repeat (5) tick();
        rxf(29'h55, 0, 4'd1, 64'h2);
        rd_chk(SEL_TIMER, 0, 32'hFFFFFFFF, 0, "R9 timer resync");

        busoff_evt = 1; wake_evt = 1; tick(); busoff_evt = 0; wake_evt = 0;
        rd_chk(SEL_IFLAG, 0, 32'h70000, 32'h50000, "R10 event flags");
        hw(SEL_CFG, 0, 32'h4);
        err_evt = 1; tick(); err_evt = 0;
        chk(ack_en === 0 && tx_req === 0, "R11 listen-only quiet", {ack_en, tx_req}, 0);
        rd_chk(SEL_IFLAG, 0, 32'h20000, 0, "R11 error flag held");
        hw(SEL_IFLAG, 0, 32'h7FFFF);
        chk(irq === 0, "R10 irq cleared", irq, 0);
        repeat (3) tick();
        finish_run();
    end
endmodule